// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives a raw 8-bit NAND flash bus on behalf of a host that issues one primitive operation at a time. The primitives are: latch a command byte, latch an address byte, latch a write-data byte, strobe one read-data byte back from the device, and wait for the selected device to report ready. Each operation targets one of several chip enables. Multi-byte protocols are built by host software from these primitives. Examples are identification reads, page reads and full-array dumps. The host can also check the link by re-reading the identification bytes many times and comparing the results.

All bus timing is expressed in clock cycles and set by parameters. This lets the strobes be stretched enough for roughly 20 MHz signalling over long, unterminated wiring. The host sees a ready/done handshake. Once accepted, an operation runs to completion and pulses a done flag. The wait operation gives up after a bounded number of cycles and then raises a timeout flag.

Top module: `nand_seq`

## Requirements
- R1: During reset and until the first operation is accepted, every chip enable is high, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale`, `nand_dq_oe`, `cmd_done` and `wait_timeout` are low, and `cmd_ready` is high.
- R2: A command op (`cmd_op`=0) drives `nand_cle` high and puts `cmd_byte` on `nand_dq_o` with `nand_dq_oe` high. It holds `nand_we_n` low for exactly `WE_LOW` cycles, starting in the cycle after acceptance. `nand_we_n` then rises while the byte and `nand_cle` are still held, and both stay held for `HOLD` more cycles.
- R3: An address op (`cmd_op`=1) has the same timing as R2 but uses `nand_ale` in place of `nand_cle`. A write-data op (`cmd_op`=2) keeps both `nand_cle` and `nand_ale` low. `nand_cle` and `nand_ale` are never high together.
- R4: A read op (`cmd_op`=3) holds `nand_re_n` low for `RD_DLY` cycles. It captures `nand_dq_i` into `rd_byte` on the edge where `nand_re_n` rises, and keeps `nand_we_n` high and `nand_dq_oe` low throughout. `rd_byte` holds its value until the next read op.
- R5: A wait op (`cmd_op`=4) completes in the first cycle after a clock edge at which `nand_rb` of the selected chip is high (high means ready). This is at the earliest the edge after acceptance. `wait_timeout` is left low.
- R6: If the selected `nand_rb` is still low after `TIMEOUT`+1 edges from acceptance, the wait op completes and sets `wait_timeout`. `wait_timeout` clears when the next op of any kind is accepted.
- R7: The chip enable indexed by `cmd_ce` goes low from the cycle after acceptance and stays low after the op ends, until another op selects a different chip. At most one chip enable is low. The ready line of an unselected chip has no effect.
- R8: `cmd_ready` is low exactly while an op is in flight, and `cmd_valid` is ignored in that time. `cmd_done` is a one-cycle pulse in the cycle `cmd_ready` returns high. A write-type op completes `WE_LOW`+`HOLD` cycles after acceptance, and a read op completes `RD_DLY`+`HOLD` cycles after acceptance.
- R9: Op codes 5 to 7 are accepted, update the chip selection, clear `wait_timeout` and pulse `cmd_done` in the cycle after acceptance. They produce no strobe and no bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host requests an op; taken when `cmd_ready` is high |
| cmd_op | input | 3 | 0 command, 1 address, 2 write data, 3 read data, 4 wait ready |
| cmd_ce | input | CE_W | Index of the target chip enable |
| cmd_byte | input | DW | Byte to place on the bus for write-type ops |
| cmd_ready | output | 1 | No op in flight |
| cmd_done | output | 1 | One-cycle pulse when an op finishes |
| rd_byte | output | DW | Byte captured by the latest read op |
| wait_timeout | output | 1 | Latest wait op expired before ready |
| nand_ce_n | output | NCE | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | DW | Bus data driven to the device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | DW | Bus data from the device |
| nand_rb | input | NCE | Ready (high) / busy (low), one per chip |

## Verification
A corrupted phase or counter in this block would show at the ports within a single cycle. A strobe would be too short or too long. A latch line would drop before its rising edge, or `cmd_done` would appear early, late or twice. The bench therefore compares every strobe, latch line, chip enable and handshake flag against a behavioural model on every clock. A stale captured byte or a sticky timeout flag would only be visible at the end of the next read or wait. For that reason, the identification reads use a different byte each time, and a timeout is always followed by further ops.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_CMD   = 3'd0,
        OP_ADDR  = 3'd1,
        OP_WDATA = 3'd2,
        OP_RDATA = 3'd3,
        OP_WAIT  = 3'd4
    } seq_op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_HOLD   = 2'd2,
        PH_POLL   = 2'd3
    } seq_phase_e;

endpackage

// File: rtl/nand_seq_timer.sv
module nand_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nand_seq_ce_decode.sv
module nand_seq_ce_decode #(
    parameter int NCE  = 2,
    parameter int CE_W = 1
) (
    input  logic [CE_W-1:0] sel,
    input  logic            active,
    input  logic [NCE-1:0]  rb_all,
    output logic [NCE-1:0]  ce_n,
    output logic            rb_sel
);
    logic [NCE-1:0] hit;

    for (genvar g = 0; g < NCE; g++) begin : g_ce
        assign hit[g]  = active && (sel == CE_W'(g));
        assign ce_n[g] = ~hit[g];
    end

    assign rb_sel = |(hit & rb_all);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int DW      = 8,
    parameter int NCE     = 2,
    parameter int WE_LOW  = 3,
    parameter int RD_DLY  = 4,
    parameter int HOLD    = 2,
    parameter int TIMEOUT = 4096,
    localparam int CE_W   = (NCE > 1) ? $clog2(NCE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [CE_W-1:0] cmd_ce,
    input  logic [DW-1:0]   cmd_byte,
    output logic            cmd_ready,
    output logic            cmd_done,
    output logic [DW-1:0]   rd_byte,
    output logic            wait_timeout,
    output logic [NCE-1:0]  nand_ce_n,
    output logic            nand_cle,
    output logic            nand_ale,
    output logic            nand_we_n,
    output logic            nand_re_n,
    output logic [DW-1:0]   nand_dq_o,
    output logic            nand_dq_oe,
    input  logic [DW-1:0]   nand_dq_i,
    input  logic [NCE-1:0]  nand_rb
);
    localparam int M1 = (WE_LOW > RD_DLY) ? WE_LOW : RD_DLY;
    localparam int M2 = (M1 > HOLD) ? M1 : HOLD;
    localparam int MX = (M2 > TIMEOUT) ? M2 : TIMEOUT;
    localparam int CW = $clog2(MX + 1);

    typedef struct packed {
        seq_phase_e      phase;
        logic [2:0]      op;
        logic [CE_W-1:0] sel;
        logic            any_sel;
        logic            cle;
        logic            ale;
        logic            we_n;
        logic            re_n;
        logic [DW-1:0]   dq;
        logic            oe;
        logic [DW-1:0]   rd;
        logic            err;
        logic            done;
    } seq_state_t;

    seq_state_t    s_d, s_q;
    logic          t_load, t_dec, t_zero, rb_sel;
    logic [CW-1:0] t_val;

    nand_seq_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
        .dec(t_dec), .zero(t_zero)
    );

    nand_seq_ce_decode #(.NCE(NCE), .CE_W(CE_W)) u_ce (
        .sel(s_q.sel), .active(s_q.any_sel), .rb_all(nand_rb),
        .ce_n(nand_ce_n), .rb_sel(rb_sel)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        t_load   = 1'b0;
        t_dec    = 1'b0;
        t_val    = '0;
        unique case (s_q.phase)
            PH_IDLE: if (cmd_valid) begin
                s_d.sel     = cmd_ce;
                s_d.any_sel = 1'b1;
                s_d.op      = cmd_op;
                s_d.err     = 1'b0;
                if (cmd_op == OP_CMD || cmd_op == OP_ADDR || cmd_op == OP_WDATA) begin
                    s_d.cle   = (cmd_op == OP_CMD);
                    s_d.ale   = (cmd_op == OP_ADDR);
                    s_d.dq    = cmd_byte;
                    s_d.oe    = 1'b1;
                    s_d.we_n  = 1'b0;
                    s_d.phase = PH_STROBE;
                    t_load    = 1'b1;
                    t_val     = CW'(WE_LOW - 1);
                end else if (cmd_op == OP_RDATA) begin
                    s_d.re_n  = 1'b0;
                    s_d.phase = PH_STROBE;
                    t_load    = 1'b1;
                    t_val     = CW'(RD_DLY - 1);
                end else if (cmd_op == OP_WAIT) begin
                    s_d.phase = PH_POLL;
                    t_load    = 1'b1;
                    t_val     = CW'(TIMEOUT);
                end else begin
                    s_d.done  = 1'b1;
                end
            end
            PH_STROBE: if (t_zero) begin
                s_d.we_n  = 1'b1;
                s_d.re_n  = 1'b1;
                if (s_q.op == OP_RDATA) s_d.rd = nand_dq_i;
                s_d.phase = PH_HOLD;
                t_load    = 1'b1;
                t_val     = CW'(HOLD - 1);
            end else begin
                t_dec = 1'b1;
            end
            PH_HOLD: if (t_zero) begin
                s_d.cle   = 1'b0;
                s_d.ale   = 1'b0;
                s_d.oe    = 1'b0;
                s_d.done  = 1'b1;
                s_d.phase = PH_IDLE;
            end else begin
                t_dec = 1'b1;
            end
            PH_POLL: if (rb_sel) begin
                s_d.done  = 1'b1;
                s_d.phase = PH_IDLE;
            end else if (t_zero) begin
                s_d.err   = 1'b1;
                s_d.done  = 1'b1;
                s_d.phase = PH_IDLE;
            end else begin
                t_dec = 1'b1;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.we_n  <= 1'b1;
            s_q.re_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready    = (s_q.phase == PH_IDLE);
    assign cmd_done     = s_q.done;
    assign rd_byte      = s_q.rd;
    assign wait_timeout = s_q.err;
    assign nand_cle     = s_q.cle;
    assign nand_ale     = s_q.ale;
    assign nand_we_n    = s_q.we_n;
    assign nand_re_n    = s_q.re_n;
    assign nand_dq_o    = s_q.dq;
    assign nand_dq_oe   = s_q.oe;

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);
    // R8: no completion while still busy
    a_r8_done_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> cmd_ready);
    // R3: latch lines exclusive
    a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R4: no bus drive while reading
    a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> (!nand_dq_oe && nand_we_n));
    // R7: at most one chip enabled
    a_r7_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~nand_ce_n) <= 1);
    // R2: byte still driven when the write strobe rises
    a_r2_we_rise_driven: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (nand_dq_oe && $stable(nand_dq_o)));
endmodule

// File: tb/nand_seq_test.sv
`timescale 1ns/1ps
module nand_seq_test;
    localparam int DW = 8, NCE = 2, WE_LOW = 3, RD_DLY = 4, HOLD = 2, TMO = 20;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0;
    logic [2:0] cmd_op = 0;
    logic [0:0] cmd_ce = 0;
    logic [7:0] cmd_byte = 0;
    logic cmd_ready, cmd_done, wait_timeout;
    logic [7:0] rd_byte, nand_dq_o;
    logic [1:0] nand_ce_n;
    logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_i = 8'h00;
    logic [1:0] nand_rb = 2'b00;

    int checks = 0, errors = 0, cyc = 0;
    bit model_on = 0;

    always #2.5 clk = ~clk;

    nand_seq #(.DW(DW), .NCE(NCE), .WE_LOW(WE_LOW), .RD_DLY(RD_DLY),
               .HOLD(HOLD), .TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ce(cmd_ce), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
        .cmd_done(cmd_done), .rd_byte(rd_byte), .wait_timeout(wait_timeout),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 strobe, 2 hold, 3 poll
    int m_ph, m_left, m_op, m_sel;
    bit m_any, m_cle, m_ale, m_we, m_re, m_oe, m_done, m_err;
    logic [7:0] m_dq, m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_op = 0; m_sel = 0; m_any = 0;
            m_cle = 0; m_ale = 0; m_we = 1; m_re = 1; m_oe = 0;
            m_done = 0; m_err = 0; m_dq = 0; m_rd = 0;
        end else begin
            cyc++;
            m_done = 0;
            if (m_ph == 0) begin
                if (cmd_valid) begin
                    m_sel = cmd_ce; m_any = 1; m_err = 0; m_op = cmd_op;
                    if (m_op <= 2) begin
                        m_cle = (m_op == 0); m_ale = (m_op == 1);
                        m_dq = cmd_byte; m_oe = 1; m_we = 0;
                        m_ph = 1; m_left = WE_LOW - 1;
                    end else if (m_op == 3) begin
                        m_re = 0; m_ph = 1; m_left = RD_DLY - 1;
                    end else if (m_op == 4) begin
                        m_ph = 3; m_left = TMO;
                    end else m_done = 1;
                end
            end else if (m_ph == 1) begin
                if (m_left == 0) begin
                    m_we = 1; m_re = 1;
                    if (m_op == 3) m_rd = nand_dq_i;
                    m_ph = 2; m_left = HOLD - 1;
                end else m_left--;
            end else if (m_ph == 2) begin
                if (m_left == 0) begin
                    m_cle = 0; m_ale = 0; m_oe = 0; m_done = 1; m_ph = 0;
                end else m_left--;
            end else begin
                if (nand_rb[m_sel]) begin
                    m_done = 1; m_ph = 0;
                end else if (m_left == 0) begin
                    m_err = 1; m_done = 1; m_ph = 0;
                end else m_left--;
            end
        end
    end

    always @(negedge clk) if (model_on) begin
        check("R2 we_n", nand_we_n, m_we);
        check("R2 cle", nand_cle, m_cle);
        check("R3 ale", nand_ale, m_ale);
        check("R4 re_n", nand_re_n, m_re);
        check("R4 rd_byte", rd_byte, m_rd);
        check("R2 dq_oe", nand_dq_oe, m_oe);
        if (m_oe) check("R2 dq_o", nand_dq_o, m_dq);
        check("R6 wait_timeout", wait_timeout, m_err);
        check("R7 ce_n", nand_ce_n, m_any ? (~(2'b01 << m_sel) & 2'b11) : 2'b11);
        check("R8 ready", cmd_ready, m_ph == 0);
        check("R8 done", cmd_done, m_done);
    end

    // returns cycles from acceptance edge to the edge that raised done
    task automatic issue(input int op, input int ce, input int b, output int c);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op[2:0]; cmd_ce = ce[0:0]; cmd_byte = b[7:0];
        @(negedge clk);
        cmd_valid = 0;
        c = 0;
        while (!cmd_done && c < 1000) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        int c;
        logic [7:0] ids [5];
        ids[0] = 8'hEC; ids[1] = 8'hD7; ids[2] = 8'h94; ids[3] = 8'h7E; ids[4] = 8'h64;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ce_n", nand_ce_n, 2'b11);
        check("R1 we_n", nand_we_n, 1);
        check("R1 re_n", nand_re_n, 1);
        check("R1 latch", {nand_cle, nand_ale, nand_dq_oe}, 0);
        check("R1 flags", {cmd_ready, cmd_done, wait_timeout}, 3'b100);
        rst_n = 1;
        model_on = 1;
        @(negedge clk);
        check("R1 ce_n idle", nand_ce_n, 2'b11);

        // ID read on chip 0, repeated to compare bytes
        for (int pass = 0; pass < 2; pass++) begin
            issue(0, 0, 8'h90, c);
            check("R2 cmd length", c, WE_LOW + HOLD);
            issue(1, 0, 8'h00, c);
            check("R3 addr length", c, WE_LOW + HOLD);
            for (int k = 0; k < 5; k++) begin
                nand_dq_i = ids[k];
                issue(3, 0, 0, c);
                nand_dq_i = 8'h5A;
                check("R4 read length", c, RD_DLY + HOLD);
                check("R4 id byte", rd_byte, ids[k]);
            end
        end
        check("R7 ce held", nand_ce_n, 2'b10);

        // write data on chip 1; a second request while busy is dropped
        fork
            issue(2, 1, 8'h3C, c);
            begin
                @(negedge clk); @(negedge clk);
                cmd_valid = 1; cmd_op = 3'd0; cmd_byte = 8'hFF;
                @(negedge clk);
                cmd_valid = 0;
            end
        join
        check("R3 wdata length", c, WE_LOW + HOLD);
        check("R4 rd_byte kept", rd_byte, ids[4]);
        repeat (3) @(negedge clk);
        check("R8 busy request ignored", cmd_ready, 1);

        // wait on chip 1: becomes ready a few cycles in
        nand_rb = 2'b00;
        fork
            issue(4, 1, 0, c);
            begin repeat (6) @(negedge clk); nand_rb[1] = 1; end
        join
        check("R5 no timeout", wait_timeout, 0);

        // wait on chip 0 while chip 1 is ready: must time out
        nand_rb = 2'b10;
        issue(4, 0, 0, c);
        check("R6 timeout length", c, TMO + 1);
        check("R6 timeout flag", wait_timeout, 1);
        check("R7 other rb ignored", nand_ce_n, 2'b10);

        // ready already high: done one edge after acceptance
        nand_rb = 2'b01;
        issue(4, 0, 0, c);
        check("R5 immediate", c, 1);
        check("R6 flag cleared", wait_timeout, 0);

        // time out again, then an unused opcode clears it
        nand_rb = 2'b00;
        issue(4, 1, 0, c);
        check("R6 timeout again", wait_timeout, 1);
        issue(6, 0, 8'hAA, c);
        check("R9 unused op length", c, 0);
        check("R9 flag cleared", wait_timeout, 0);
        check("R9 ce switched", nand_ce_n, 2'b10);
        check("R9 no drive", {nand_dq_oe, nand_cle, nand_ale}, 0);
        issue(7, 1, 8'hAA, c);
        check("R9 ce switched again", nand_ce_n, 2'b01);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule